// File: doc/BRIEF.md
# Systolic Ones Counter

This block counts the set bits of an N-bit vector. It accepts a new vector on every clock and returns each count a fixed number of cycles later. The design avoids an adder tree. Bit k of a vector is held back by k registers in a triangular skew grid. The skewed bit then meets that vector's running count in row k of a linear column of carry-save incrementers. Every register-to-register path is therefore at most one full-adder level deep, and the wiring between rows is purely local.

Below the incrementer column, a short resolve pipeline turns the carry-save pair into a binary count. This pipeline has one stage per count bit, so it is about log2(N) stages deep. A valid flag travels with each vector. Empty slots carry zeros through the array, so the output count reads zero whenever no result is present. The block suits wide streaming data paths, where a high clock rate matters more than register count.

Top module: `popc_systolic`

## Requirements
- R1: For every vector sampled with `in_valid` high, `out_count` equals the number of bits set in `in_vec`.
- R2: A vector sampled at a rising edge produces its result on the outputs directly after the LAT-th rising edge, counting the sampling edge as the first. LAT = N + ceil(log2(N+1)), which is 12 for N = 8. A new vector is taken on every edge, and back-to-back vectors give back-to-back results.
- R3: When `in_valid` is low, `in_vec` is ignored. The matching output slot, LAT edges later, shows `out_valid` low and `out_count` zero.
- R4: Each incrementer row keeps its partial count as a sum vector plus a carry vector. The value of sum plus carry after a row equals the value before it plus the arriving bit.
- R5: The all-zero vector gives a count of 0, and the all-ones vector gives N (binary 1000 for N = 8). `out_count` never exceeds N.
- R6: `rst` is synchronous and active high. It clears every register, so `out_valid` and `out_count` are zero after it. Vectors in flight when reset is applied never appear, and vectors presented while `rst` is high are discarded.
- R7: Stage j of the resolve pipeline fixes count bit j and passes a single carry upward. The value held across the resolved bits, the remaining sum and carry bits and the carry is the same before and after each stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_vec` as a vector to count |
| in_vec | input | N | Vector whose set bits are counted |
| out_valid | output | 1 | Marks `out_count` as a result |
| out_count | output | ceil(log2(N+1)) | Registered number of set bits |

## Verification
With N = 8, a vector driven before edge k has its count and flag due right after edge k+11. The bench stores each expectation in a slot indexed by that edge number. On every falling clock edge it compares both outputs against the slot for the edge just passed, so every result is checked in exactly the cycle it is due, and no earlier or later cycle can match by chance. The sweep covers all 256 vectors back to back, a gapped stream with junk data in the idle slots, boundary vectors, and a reset applied with vectors in flight. On that reset the bench overwrites the pending slots with empty expectations.

// File: rtl/popc_pkg.sv
package popc_pkg;

  // Bits needed to hold a count from 0 to n.
  function automatic int cnt_width(int n);
    return $clog2(n + 1);
  endfunction

  // Numeric value of a partly resolved carry-save word: resolved low bits
  // below position p, plus remaining sum/carry bits at or above p, plus the
  // pending carry entering position p.
  function automatic logic [31:0] csa_value(logic [31:0] r, logic [31:0] s,
                                            logic [31:0] c, logic k, int p);
    logic [31:0] hi_mask;
    hi_mask = ~((32'd1 << p) - 32'd1);
    return (r & ~hi_mask) + (s & hi_mask) + (c & hi_mask) + ({31'd0, k} << p);
  endfunction

endpackage

// File: rtl/popc_skew_grid.sv
// Triangular delay grid: row k holds k flip-flops, so bit k leaves the grid
// k clocks after it entered, one diagonal step per clock.
module popc_skew_grid #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in_bits,
  output logic [N-1:0] out_bits
);

  for (genvar k = 0; k < N; k++) begin : g_row
    if (k == 0) begin : g_direct
      assign out_bits[k] = in_bits[k];
    end else if (k == 1) begin : g_one
      logic diag_q;
      always_ff @(posedge clk) begin
        if (rst) diag_q <= 1'b0;
        else     diag_q <= in_bits[k];
      end
      assign out_bits[k] = diag_q;
    end else begin : g_many
      logic [k-1:0] diag_q;
      always_ff @(posedge clk) begin
        if (rst) diag_q <= '0;
        else     diag_q <= {diag_q[k-2:0], in_bits[k]};
      end
      assign out_bits[k] = diag_q[k-1];
    end
  end

endmodule

// File: rtl/popc_csa_cell.sv
// One row of the incrementer column: adds a single bit to a carry-save
// partial count with one full-adder level per bit position.
module popc_csa_cell #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  input  logic         bit_i,
  output logic         vld_o,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);

  logic [W-1:0] inc_vec;
  logic [W-1:0] sum_n;
  logic [W-1:0] maj_n;

  assign inc_vec = {{(W-1){1'b0}}, bit_i};
  assign sum_n   = s_i ^ c_i ^ inc_vec;
  assign maj_n   = (s_i & c_i) | (s_i & inc_vec) | (c_i & inc_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      s_o   <= '0;
      c_o   <= '0;
    end else begin
      vld_o <= vld_i;
      s_o   <= sum_n;
      c_o   <= {maj_n[W-2:0], 1'b0};
    end
  end

  // R4: numeric value of the pair grows by exactly the arriving bit
  p_csa_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ({1'b0, s_o} + {1'b0, c_o}) ==
             $past({1'b0, s_i} + {1'b0, c_i} + {{W{1'b0}}, bit_i}));

endmodule

// File: rtl/popc_resolve.sv
// Pipelined carry resolution: stage j settles result bit j and hands one
// carry bit to stage j+1.
module popc_resolve #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  output logic         vld_o,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] q_r [W];
  logic [W-1:0] q_s [W];
  logic [W-1:0] q_c [W];
  logic         q_k [W];
  logic         q_v [W];
  logic [W-1:0] d_r [W];
  logic [W-1:0] d_s [W];
  logic [W-1:0] d_c [W];
  logic         d_k [W];
  logic         d_v [W];

  always_comb begin
    for (int j = 0; j < W; j++) begin
      logic [W-1:0] pr, ps, pc;
      logic         pk, pv;
      if (j == 0) begin
        pr = '0;
        ps = s_i;
        pc = c_i;
        pk = 1'b0;
        pv = vld_i;
      end else begin
        pr = q_r[j-1];
        ps = q_s[j-1];
        pc = q_c[j-1];
        pk = q_k[j-1];
        pv = q_v[j-1];
      end
      d_r[j]    = pr;
      d_r[j][j] = ps[j] ^ pc[j] ^ pk;
      d_k[j]    = (ps[j] & pc[j]) | (ps[j] & pk) | (pc[j] & pk);
      d_s[j]    = ps;
      d_c[j]    = pc;
      d_v[j]    = pv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < W; j++) begin
        q_r[j] <= '0;
        q_s[j] <= '0;
        q_c[j] <= '0;
        q_k[j] <= 1'b0;
        q_v[j] <= 1'b0;
      end
    end else begin
      for (int j = 0; j < W; j++) begin
        q_r[j] <= d_r[j];
        q_s[j] <= d_s[j];
        q_c[j] <= d_c[j];
        q_k[j] <= d_k[j];
        q_v[j] <= d_v[j];
      end
    end
  end

  assign cnt_o = q_r[W-1];
  assign vld_o = q_v[W-1];

  // R7: every resolve stage keeps the numeric value of what it carries
  for (genvar j = 0; j < W; j++) begin : g_chk
    if (j == 0) begin : g_first
      p_resolve_keep_r7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> popc_pkg::csa_value(32'(q_r[j]), 32'(q_s[j]), 32'(q_c[j]), q_k[j], j + 1) ==
                 $past(popc_pkg::csa_value(32'd0, 32'(s_i), 32'(c_i), 1'b0, 0)));
    end else begin : g_next
      p_resolve_keep_r7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> popc_pkg::csa_value(32'(q_r[j]), 32'(q_s[j]), 32'(q_c[j]), q_k[j], j + 1) ==
                 $past(popc_pkg::csa_value(32'(q_r[j-1]), 32'(q_s[j-1]), 32'(q_c[j-1]),
                                           q_k[j-1], j)));
    end
  end

endmodule

// File: rtl/popc_systolic.sv
module popc_systolic #(
  parameter int N = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [N-1:0]             in_vec,
  output logic                     out_valid,
  output logic [$clog2(N+1)-1:0]   out_count
);

  localparam int W   = popc_pkg::cnt_width(N);
  localparam int LAT = N + W;
  localparam int FW  = $clog2(LAT + 1);

  logic [N-1:0] gated_vec;
  logic [N-1:0] skewed;
  logic [W-1:0] row_s [N];
  logic [W-1:0] row_c [N];
  logic         row_v [N];

  // Idle slots enter as zeros so nothing stale can reach the count.
  assign gated_vec = in_vec & {N{in_valid}};

  popc_skew_grid #(.N(N)) u_skew (
    .clk      (clk),
    .rst      (rst),
    .in_bits  (gated_vec),
    .out_bits (skewed)
  );

  for (genvar k = 0; k < N; k++) begin : g_col
    if (k == 0) begin : g_top
      popc_csa_cell #(.W(W)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .vld_i (in_valid),
        .s_i   ({W{1'b0}}),
        .c_i   ({W{1'b0}}),
        .bit_i (skewed[k]),
        .vld_o (row_v[k]),
        .s_o   (row_s[k]),
        .c_o   (row_c[k])
      );
    end else begin : g_below
      popc_csa_cell #(.W(W)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .vld_i (row_v[k-1]),
        .s_i   (row_s[k-1]),
        .c_i   (row_c[k-1]),
        .bit_i (skewed[k]),
        .vld_o (row_v[k]),
        .s_o   (row_s[k]),
        .c_o   (row_c[k])
      );
    end
  end

  popc_resolve #(.W(W)) u_resolve (
    .clk   (clk),
    .rst   (rst),
    .vld_i (row_v[N-1]),
    .s_i   (row_s[N-1]),
    .c_i   (row_c[N-1]),
    .vld_o (out_valid),
    .cnt_o (out_count)
  );

  // Cycles since reset, saturating at the pipeline depth.
  logic [FW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                          since_rst <= '0;
    else if (since_rst != FW'(LAT))   since_rst <= since_rst + 1'b1;
  end

  // R6: nothing emerges before the pipeline has refilled after reset
  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst < FW'(LAT)) |-> !out_valid);

  // R3: empty output slots carry a zero count
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_count == '0);

  // R5: a count can never exceed the vector width
  p_out_range_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> 32'(out_count) <= 32'(N));

endmodule

// File: tb/test_popc_systolic.sv
module test_popc_systolic;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 8;
  localparam int W     = $clog2(N + 1);
  localparam int LAT   = N + W;
  localparam int SLOTS = 2048;
  localparam int LIMIT = 3000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_vec = '0;
  logic         out_valid;
  logic [W-1:0] out_count;

  int    ec = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  bit    ev   [SLOTS];
  int    ecnt [SLOTS];
  string etag [SLOTS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  popc_systolic #(.N(N)) i_popc_systolic (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_count (out_count)
  );

  always @(posedge clk) begin
    ec <= ec + 1;
    if (ec > LIMIT && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: actual edge %0d expected finish before %0d", ec, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic int ones(logic [N-1:0] v);
    int n = 0;
    for (int b = 0; b < N; b++) n += int'(v[b]);
    return n;
  endfunction

  // Output checks, one slot per edge, away from the active edge.
  always @(negedge clk) begin
    if (ec >= 1 && !done) begin
      int    idx;
      string t;
      idx = ec % SLOTS;
      t   = (etag[idx] == "") ? "R6" : etag[idx];
      n_cmp++;
      if (out_valid !== ev[idx]) begin
        n_bad++;
        $display("FAIL %s out_valid at edge %0d: actual %b expected %b",
                 ev[idx] ? "R2" : t, ec, out_valid, ev[idx]);
      end
      // R1 count; R4 and R7 keep the carried value intact along the way
      n_cmp++;
      if (out_count !== W'(ecnt[idx])) begin
        n_bad++;
        $display("FAIL %s out_count at edge %0d: actual %0d expected %0d",
                 t, ec, out_count, ecnt[idx]);
      end
    end
  end

  // Drive one slot before the next edge and record its due slot.
  task automatic drive(input bit v, input logic [N-1:0] vec);
    int idx, c;
    @(negedge clk);
    in_valid = v;
    in_vec   = vec;
    idx = (ec + LAT) % SLOTS;
    c   = ones(vec);
    ev[idx]   = v;
    ecnt[idx] = v ? c : 0;
    if (!v)                   etag[idx] = "R3";
    else if (c == 0 || c == N) etag[idx] = "R5";
    else                       etag[idx] = "R1";
  endtask

  task automatic wipe_pending();
    for (int i = 1; i <= LAT; i++) begin
      ev[(ec + i) % SLOTS]   = 1'b0;
      ecnt[(ec + i) % SLOTS] = 0;
      etag[(ec + i) % SLOTS] = "R6";
    end
  endtask

  initial begin
    // R6: reset state checked on the slots before release
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 R2: every vector, one per clock
    for (int i = 0; i < (1 << N); i++) drive(1'b1, N'(i));

    // R3: gapped stream with junk data in idle slots
    for (int i = 0; i < 64; i++) drive((i % 3) != 0, N'((i * 37) ^ 8'hA5));

    // R5: boundaries and single bits
    drive(1'b1, '1);
    drive(1'b1, '0);
    drive(1'b1, '1);
    for (int b = 0; b < N; b++) drive(1'b1, N'(1) << b);
    drive(1'b0, '1);
    drive(1'b1, '1);

    // R6: reset with vectors in flight, data offered during reset
    for (int i = 0; i < 5; i++) drive(1'b1, N'(8'hF0 + i));
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_vec = '1;
    wipe_pending();
    @(negedge clk);
    in_vec = 8'h0F;
    wipe_pending();
    for (int i = 0; i < 6; i++) drive(1'b1, N'(8'h3C + i * 11));
    // rst is released by the first drive above
    drain();
  end

  task automatic drain();
    for (int i = 0; i < LAT + 3; i++) drive(1'b0, '0);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Release reset together with the first post-reset slot.
  always @(negedge clk) begin
    if (rst && ec > 5 && in_vec == N'(8'h3C) && in_valid) rst = 1'b0;
  end

endmodule